// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block produces a divided copy of the oscillator clock for an output pin. A single 8-bit control register on a simple bus holds an output-enable bit and a 4-bit rate code. A separate mode input picks the base clock: the oscillator itself, or half of it. The rate code then selects one of eight power-of-two divisions of that base clock. The full range runs from the oscillator rate down to the oscillator divided by 256.

A free-running counter clocked by the oscillator supplies every divided rate. The output is the counter bit that matches the selected ratio. The undivided rate bypasses the counter and passes through a latch-based clock gate. Starting and stopping the output are held back until the selected clock is low, so no shortened pulse reaches the pin. The ratio is captured when the output starts and is kept until it stops again.

Software must load the rate code while the output is off, then set the enable bit. A prohibited rate code with the enable bit set keeps the pin low and sets a sticky error flag.

Top module: `clkout_divider`

## Requirements
- R1: The control register answers only at bus address REG_ADDR (default FF40h). A write there with `bus_sel` and `bus_wr` high stores the data. A read there returns the register. Writes to any other address change nothing, and reads from any other address return 00h.
- R2: After reset the register reads 00h, `clk_out` is low and `code_err` is low.
- R3: Register bits 6 to 4 always read as 0, whatever was written to them. Bit 7 is the enable bit and bits 3 to 0 are the rate code.
- R4: With the enable bit set and a rate code c from 5 to 12, `clk_out` has a 50% duty cycle. Its period is 2^(c-5) oscillator cycles when `osc_full` is 1, and 2^(c-4) oscillator cycles when `osc_full` is 0.
- R5: Code 5 with `osc_full` at 1 passes the oscillator clock to `clk_out` unchanged while the output is enabled.
- R6: While the enable bit is 0, and once the current pulse has ended, `clk_out` stays low.
- R7: Setting or clearing the enable bit never produces a high pulse on `clk_out` shorter than half the selected period.
- R8: A change of the rate code or of `osc_full` while the output runs has no effect on `clk_out` until the output has been stopped and started again.
- R9: Codes 0 to 4 and 13 to 15 are prohibited. A prohibited code with the enable bit set keeps `clk_out` low and sets `code_err`, which stays set until reset. A prohibited code written with the enable bit clear leaves `code_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; also clocks the register and the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_full | input | 1 | Base clock select: 1 = oscillator, 0 = oscillator / 2 |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier for the bus access |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 00h when the address does not match |
| clk_out | output | 1 | Divided clock for the pin; low when disabled |
| code_err | output | 1 | Sticky flag for an enable with a prohibited code |

## Verification
The start or stop of the output and a rising edge of the selected divided clock can fall on the same oscillator edge. The bench provokes this by setting and clearing the enable bit at several different offsets from the counter phase. It then measures every complete high pulse on `clk_out`. Each pulse that begins or ends near such a change must still last exactly half the period, and the pulse count and high-sample count over whole periods must match the chosen ratio.

// File: rtl/clkout_pkg.sv
// Package: types shared by the clock output divider.
// Assumes an 8-bit control register with the enable bit at the top and the
// rate code in the low nibble.
package clkout_pkg;
    localparam int CODE_W = 4;

    // Stored fields of the control register.
    typedef struct packed {
        logic              on;
        logic [CODE_W-1:0] code;
    } ctl_reg_t;
endpackage

// File: rtl/clkout_regs.sv
// Module: control register on the simple bus.
// Assumes single-cycle accesses and a combinational read path. Bits 6..4 are
// not stored and read as zero.
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output ctl_reg_t          ctl
);
    localparam int PAD_W = 8 - 1 - CODE_W;

    logic hit;

    // Address decode for this register.
    always_comb hit = bus_sel && (bus_addr == REG_ADDR);

    // Register update on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (hit && bus_wr) begin
            ctl.on   <= bus_wdata[7];
            ctl.code <= bus_wdata[CODE_W-1:0];
        end
    end

    // Read mux: register with zero padding, else zero.
    always_comb bus_rdata = hit ? {ctl.on, {PAD_W{1'b0}}, ctl.code} : 8'h00;
endmodule

// File: rtl/clkout_counter.sv
// Module: free-running synchronous divider counter.
// Assumes it runs from the oscillator clock; bit i toggles every 2^i cycles.
module clkout_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // Count up every oscillator cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clkout_tap.sv
// Module: picks the counter bit for a division shift.
// Shift k > 0 selects bit k-1, giving a period of 2^k; shift 0 gives zero
// (the undivided path is handled elsewhere).
module clkout_tap #(
    parameter int CNT_W = 8,
    parameter int SH_W  = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [SH_W-1:0]  shift,
    output logic             tap
);
    // Bit select over all counter stages.
    always_comb begin
        tap = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            if (int'(shift) == i + 1) tap = cnt[i];
        end
    end
endmodule

// File: rtl/clkout_ctrl.sv
// Module: run control, ratio capture and error flag.
// Assumes the counter is free-running. Start and stop are taken only at an
// edge where the relevant divided clock is low; the ratio is captured at start.
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SH_W     = 4,
    parameter int CODE_MIN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_reg_t         ctl,
    input  logic             osc_full,
    input  logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic [SH_W-1:0]  shift,
    output logic             err
);
    localparam int CODE_MAX = CODE_MIN + CNT_W - 1;

    logic            legal;
    logic            req;
    logic [SH_W-1:0] shift_new;
    logic            tap_new;
    logic            tap_cur;

    // Code range check and run request.
    always_comb begin
        legal = (int'(ctl.code) >= CODE_MIN) && (int'(ctl.code) <= CODE_MAX);
        req   = ctl.on && legal;
    end

    // Shift for the requested code and base-clock mode.
    always_comb begin
        shift_new = SH_W'(int'(ctl.code) - CODE_MIN + (osc_full ? 0 : 1));
    end

    clkout_tap #(.CNT_W(CNT_W), .SH_W(SH_W)) u_tap_new (
        .cnt   (cnt),
        .shift (shift_new),
        .tap   (tap_new)
    );

    clkout_tap #(.CNT_W(CNT_W), .SH_W(SH_W)) u_tap_cur (
        .cnt   (cnt),
        .shift (shift),
        .tap   (tap_cur)
    );

    // Start, stop and ratio capture at low phases of the divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            shift <= '0;
        end else if (!run) begin
            if (req && !tap_new) begin
                run   <= 1'b1;
                shift <= shift_new;
            end
        end else if (!req && !tap_cur) begin
            run <= 1'b0;
        end
    end

    // Sticky flag for an enable with a prohibited code.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (ctl.on && !legal)  err <= 1'b1;
    end
endmodule

// File: rtl/clkout_gate.sv
// Module: output stage. Divided ratios AND the run flag with a counter bit;
// the undivided ratio uses a latch that is transparent while clk is low.
// Assumes run and shift change only at rising clk edges.
module clkout_gate #(
    parameter int CNT_W = 8,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             run,
    input  logic [SH_W-1:0]  shift,
    input  logic [CNT_W-1:0] cnt,
    output logic             clk_out
);
    logic tap;
    logic bypass;
    logic gate_en;

    clkout_tap #(.CNT_W(CNT_W), .SH_W(SH_W)) u_tap (
        .cnt   (cnt),
        .shift (shift),
        .tap   (tap)
    );

    // Undivided path selected by a zero shift.
    always_comb bypass = (shift == '0);

    // Clock-gate enable latch, open during the low phase.
    always_latch begin
        if (!clk) gate_en = run && bypass;
    end

    // Output select between gated clock and divided tap.
    always_comb clk_out = bypass ? (clk && gate_en) : (run && tap);
endmodule

// File: rtl/clkout_divider.sv
// Module: top of the programmable clock output divider.
// Assumes bus accesses are synchronous to the oscillator clock.
module clkout_divider
    import clkout_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF40,
    parameter int                CNT_W    = 8,
    parameter int                CODE_MIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_full,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              clk_out,
    output logic              code_err
);
    localparam int SH_W = $clog2(CNT_W + 1);

    ctl_reg_t         ctl;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [SH_W-1:0]  run_shift;

    clkout_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctl       (ctl)
    );

    clkout_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    clkout_ctrl #(.CNT_W(CNT_W), .SH_W(SH_W), .CODE_MIN(CODE_MIN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .osc_full (osc_full),
        .cnt      (cnt),
        .run      (run),
        .shift    (run_shift),
        .err      (code_err)
    );

    clkout_gate #(.CNT_W(CNT_W), .SH_W(SH_W)) u_gate (
        .clk     (clk),
        .run     (run),
        .shift   (run_shift),
        .cnt     (cnt),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkout_divider_chk.sv
// Module: assertion checker bound into the clock output divider.
module clkout_divider_chk #(
    parameter int CNT_W    = 8,
    parameter int SH_W     = 4,
    parameter int CODE_MIN = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic [SH_W-1:0] shift,
    input logic            code_err,
    input logic            reg_on,
    input logic [3:0]      reg_code,
    input logic [7:0]      bus_rdata
);
    localparam int CODE_MAX = CODE_MIN + CNT_W - 1;

    logic code_ok;
    always_comb code_ok = (int'(reg_code) >= CODE_MIN) && (int'(reg_code) <= CODE_MAX);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);

    // R9
    bad_code_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !code_ok) |=> !run);

    // R6
    off_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_on) |=> !run);

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(shift));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[6:4] == 3'b000);
endmodule

bind clkout_divider clkout_divider_chk #(
    .CNT_W(CNT_W), .SH_W(SH_W), .CODE_MIN(CODE_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .shift     (run_shift),
    .code_err  (code_err),
    .reg_on    (ctl.on),
    .reg_code  (ctl.code),
    .bus_rdata (bus_rdata)
);

// File: tb/clkout_divider_bench.sv
`timescale 1ns/1ps
module clkout_divider_bench;
    localparam logic [15:0] REG_A = 16'hFF40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_full = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        clk_out;
    logic        code_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkout_divider u_clkout_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_full  (osc_full),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clk_out   (clk_out),
        .code_err  (code_err)
    );

    // {osc_full, code, rising edges expected in a 256-cycle window}
    localparam logic [13:0] VEC [0:6] = '{
        {1'b1, 4'd6,  9'd128},
        {1'b1, 4'd9,  9'd16},
        {1'b1, 4'd12, 9'd2},
        {1'b0, 4'd5,  9'd128},
        {1'b0, 4'd8,  9'd16},
        {1'b0, 4'd10, 9'd4},
        {1'b0, 4'd12, 9'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Samples clk_out at falling edges; counts rises, highs and complete high runs.
    task automatic measure(input int n, output int rises, output int highs,
                           output int minrun, output int maxrun);
        logic prev;
        int   len;
        bit   inrun;
        rises = 0; highs = 0; minrun = 1 << 30; maxrun = 0;
        len = 0; inrun = 1'b0;
        @(negedge clk); #1 prev = clk_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (clk_out) highs++;
            if (clk_out && !prev) begin rises++; inrun = 1'b1; len = 0; end
            if (clk_out && inrun) len++;
            if (!clk_out && prev && inrun) begin
                if (len < minrun) minrun = len;
                if (len > maxrun) maxrun = len;
                inrun = 1'b0;
            end
            prev = clk_out;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int r, h, mn, mx;

        wait_cyc(3); #1 rst_n = 1'b1;
        // R2 reset state
        rd(REG_A, d);
        chk(d == 8'h00, "R2 reg", d, 0);
        chk(clk_out == 1'b0, "R2 clk_out", clk_out, 0);
        chk(code_err == 1'b0, "R2 code_err", code_err, 0);

        // R1 other address ignored and reads zero
        wr(16'hFF41, 8'h86);
        rd(REG_A, d);
        chk(d == 8'h00, "R1 foreign write", d, 0);
        rd(16'hFF41, d);
        chk(d == 8'h00, "R1 foreign read", d, 0);

        // R3 pad bits read zero, R1 readback
        wr(REG_A, 8'h75);
        rd(REG_A, d);
        chk(d == 8'h05, "R3 pad bits", d, 5);

        // R4 vector table
        for (int v = 0; v < 7; v++) begin
            wr(REG_A, 8'h00);
            wait_cyc(300);
            osc_full = VEC[v][13];
            wr(REG_A, {4'h0, VEC[v][12:9]});
            wr(REG_A, {4'h8, VEC[v][12:9]});
            rd(REG_A, d);
            chk(d == {4'h8, VEC[v][12:9]}, "R1 readback", d, {4'h8, VEC[v][12:9]});
            wait_cyc(300);
            measure(256, r, h, mn, mx);
            chk(r == int'(VEC[v][8:0]), "R4 rises", r, int'(VEC[v][8:0]));
            chk(h == 128, "R4 duty", h, 128);
        end

        // R6 disabled output stays low
        wr(REG_A, 8'h0C);
        wait_cyc(300);
        measure(256, r, h, mn, mx);
        chk(h == 0, "R6 off low", h, 0);

        // R7 enable and disable at several phases, ratio 8 (half 4)
        osc_full = 1'b1;
        for (int dly = 0; dly < 4; dly++) begin
            wr(REG_A, 8'h08);
            wait_cyc(40 + dly);
            wr(REG_A, 8'h88);
            measure(100, r, h, mn, mx);
            chk(mn == 4 && mx == 4, "R7 start pulse", mn, 4);
            wait_cyc(dly);
            wr(REG_A, 8'h08);
            measure(60, r, h, mn, mx);
            chk(r == 0 || (mn == 4 && mx == 4), "R7 stop pulse", mn, 4);
        end

        // R8 running ratio held against code and mode changes
        wr(REG_A, 8'h00); wait_cyc(300);
        osc_full = 1'b1;
        wr(REG_A, 8'h06); wr(REG_A, 8'h86);
        wait_cyc(20);
        wr(REG_A, 8'h8C);
        osc_full = 1'b0;
        wait_cyc(20);
        measure(256, r, h, mn, mx);
        chk(r == 128, "R8 held ratio", r, 128);
        wr(REG_A, 8'h0C); wait_cyc(20);
        wr(REG_A, 8'h8C); wait_cyc(300);
        measure(256, r, h, mn, mx);
        chk(r == 1, "R8 new ratio after restart", r, 1);

        // R5 undivided pass-through
        wr(REG_A, 8'h00); wait_cyc(300);
        osc_full = 1'b1;
        wr(REG_A, 8'h05); wr(REG_A, 8'h85);
        wait_cyc(10);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            chk(clk_out == 1'b1, "R5 high phase", clk_out, 1);
            @(negedge clk); #2;
            chk(clk_out == 1'b0, "R5 low phase", clk_out, 0);
        end
        wr(REG_A, 8'h05); wait_cyc(5);
        @(posedge clk); #2;
        chk(clk_out == 1'b0, "R5 gated off", clk_out, 0);

        // R9 prohibited codes
        wr(REG_A, 8'h0D); wait_cyc(3);
        chk(code_err == 1'b0, "R9 bad code while off", code_err, 0);
        wr(REG_A, 8'h8D); wait_cyc(3);
        chk(code_err == 1'b1, "R9 err set", code_err, 1);
        measure(256, r, h, mn, mx);
        chk(h == 0, "R9 output low", h, 0);
        wr(REG_A, 8'h06); wait_cyc(3);
        chk(code_err == 1'b1, "R9 sticky", code_err, 1);
        wr(REG_A, 8'h83); wait_cyc(3);
        measure(64, r, h, mn, mx);
        chk(h == 0, "R9 low code output low", h, 0);

        // R2 reset clears flag and register
        @(posedge clk); #1 rst_n = 1'b0;
        wait_cyc(2); #1 rst_n = 1'b1;
        rd(REG_A, d);
        chk(d == 8'h00, "R2 reg after reset", d, 0);
        chk(code_err == 1'b0, "R2 err after reset", code_err, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule